// File: doc/BRIEF.md
# GPIO Interrupt Sense Bank

This block watches a bank of input lines, by default 32 of them, and turns
activity on them into a single interrupt request. Each line has its own enable
bit, a three-bit trigger selection spread across three type registers, and a
sticky status bit. Software reaches all five registers through a simple
word-addressed write port and a combinational read port. A typical use is
behind a serial GPIO master, where the parallel image of the captured inputs
is fed to `lineIn`.

Edge detection compares each line with a registered copy of its previous
sample. That copy is loaded from the live inputs while reset is held, so a
line that is steady across reset never produces an edge. A parameter selects
whether the bank can sense at all. A bank built without sensing still has
readable and writable enable and type registers, but its status never sets and
its interrupt never asserts.

Top module: `gpio_irq_sense_bank`

## Requirements
- R1: While reset is held and on leaving reset, the enable register reads 0, the type0 and type1 registers read all ones, the type2 register reads 0, the status register reads 0 and `irqOut` is low.
- R2: A line with type1=0, type2=0 and type0=1 sets its status bit on the clock edge that first sees the line high after it was low. A falling transition does not set it.
- R3: A line with type1=0, type2=0 and type0=0 sets its status bit only on a high-to-low transition.
- R4: A line with type1=0 and type2=1 sets its status bit on either transition, whatever type0 holds.
- R5: A line with type1=1 and type0=1 sets its status bit on every clock edge while the line is high, so clearing it has no lasting effect until the line goes low.
- R6: A line with type1=1 and type0=0 sets its status bit on every clock edge while the line is low.
- R7: Writing the status register (offset 0x10) clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. A clear and a new event on the same edge leave the bit set.
- R8: Status bits set whether or not enabled. `irqOut` is high exactly when some bit is set in both the status and enable registers, one edge after either changes.
- R9: A line whose value does not change, including across reset release, never sets status in an edge mode.
- R10: The register offsets are enable 0x00, type0 0x04, type1 0x08, type2 0x0C, status 0x10. Written values read back from their offsets and any other offset reads 0.
- R11: With sensing disabled by parameter, status stays 0 and `irqOut` stays low under any input and any register setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (5) | Byte offset of the register accessed |
| regWrData | input | LINES (32) | Write data |
| regRdData | output | LINES (32) | Read data for `regAddr`, combinational |
| lineIn | input | LINES (32) | Sensed input lines |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A wrong trigger decode or a stale previous-sample register shows up in the
status register one clock edge after the line moves, either as a bit that
failed to set or as one set by the wrong transition or by no transition at
all. A broken clear path shows on the very next read of status, and a wrong
enable gate shows on `irqOut` in the same cycle the status or enable register
settles. Each scenario therefore reads status directly after the edge that
should have acted, with no slack allowed.

// File: rtl/gisb_pkg.sv
package gisb_pkg;

  localparam int OFS_ENABLE = 'h00;
  localparam int OFS_TYPE0  = 'h04;
  localparam int OFS_TYPE1  = 'h08;
  localparam int OFS_TYPE2  = 'h0C;
  localparam int OFS_STATUS = 'h10;

  typedef struct packed {
    logic wrEnable;
    logic wrType0;
    logic wrType1;
    logic wrType2;
    logic clrStatus;
  } regStrobes_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_TYPE0,
    SEL_TYPE1,
    SEL_TYPE2,
    SEL_STATUS
  } readSel_t;

endpackage

// File: rtl/gisb_ctrl.sv
module gisb_ctrl
  import gisb_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobes_t       strobes,
  output readSel_t          readSel
);

  always_comb begin
    readSel = SEL_NONE;
    if (regAddr == ADDR_W'(OFS_ENABLE))      readSel = SEL_ENABLE;
    else if (regAddr == ADDR_W'(OFS_TYPE0))  readSel = SEL_TYPE0;
    else if (regAddr == ADDR_W'(OFS_TYPE1))  readSel = SEL_TYPE1;
    else if (regAddr == ADDR_W'(OFS_TYPE2))  readSel = SEL_TYPE2;
    else if (regAddr == ADDR_W'(OFS_STATUS)) readSel = SEL_STATUS;
  end

  always_comb begin
    strobes           = '0;
    strobes.wrEnable  = regWrEn && (readSel == SEL_ENABLE);
    strobes.wrType0   = regWrEn && (readSel == SEL_TYPE0);
    strobes.wrType1   = regWrEn && (readSel == SEL_TYPE1);
    strobes.wrType2   = regWrEn && (readSel == SEL_TYPE2);
    strobes.clrStatus = regWrEn && (readSel == SEL_STATUS);
  end

endmodule

// File: rtl/gisb_datapath.sv
module gisb_datapath
  import gisb_pkg::*;
#(
  parameter int LINES    = 32,
  parameter bit SENSE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strobes,
  input  readSel_t         readSel,
  input  logic [LINES-1:0] wrData,
  input  logic [LINES-1:0] lineIn,
  output logic [LINES-1:0] rdData,
  output logic             irqOut,
  output logic [LINES-1:0] enableQ,
  output logic [LINES-1:0] type0Q,
  output logic [LINES-1:0] type1Q,
  output logic [LINES-1:0] type2Q,
  output logic [LINES-1:0] statusQ,
  output logic [LINES-1:0] prevQ
);

  logic [LINES-1:0] hit;
  logic [LINES-1:0] clrMask;

  generate
    if (SENSE_EN) begin : g_sense
      logic [LINES-1:0] rise, fall, edgeHit, levelHit;
      always_comb begin
        rise     = lineIn & ~prevQ;
        fall     = ~lineIn & prevQ;
        // both-edge selection overrides the polarity bit
        edgeHit  = (type2Q & (rise | fall))
                 | (~type2Q & ((type0Q & rise) | (~type0Q & fall)));
        levelHit = ~(lineIn ^ type0Q);
        hit      = (type1Q & levelHit) | (~type1Q & edgeHit);
      end
    end else begin : g_nosense
      assign hit = '0;
    end
  endgenerate

  assign clrMask = strobes.clrStatus ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      type0Q  <= '1;
      type1Q  <= '1;
      type2Q  <= '0;
      statusQ <= '0;
      prevQ   <= lineIn;
    end else begin
      if (strobes.wrEnable) enableQ <= wrData;
      if (strobes.wrType0)  type0Q  <= wrData;
      if (strobes.wrType1)  type1Q  <= wrData;
      if (strobes.wrType2)  type2Q  <= wrData;
      statusQ <= (statusQ & ~clrMask) | hit;
      prevQ   <= lineIn;
    end
  end

  always_comb begin
    case (readSel)
      SEL_ENABLE: rdData = enableQ;
      SEL_TYPE0:  rdData = type0Q;
      SEL_TYPE1:  rdData = type1Q;
      SEL_TYPE2:  rdData = type2Q;
      SEL_STATUS: rdData = statusQ;
      default:    rdData = '0;
    endcase
  end

  assign irqOut = |(statusQ & enableQ);

endmodule

// File: rtl/gpio_irq_sense_bank.sv
module gpio_irq_sense_bank
  import gisb_pkg::*;
#(
  parameter int LINES    = 32,
  parameter int ADDR_W   = 5,
  parameter bit SENSE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LINES-1:0]  regWrData,
  output logic [LINES-1:0]  regRdData,
  input  logic [LINES-1:0]  lineIn,
  output logic              irqOut
);

  regStrobes_t      strobes;
  readSel_t         readSel;
  logic [LINES-1:0] enableQ, type0Q, type1Q, type2Q, statusQ, prevQ;

  gisb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes),
    .readSel (readSel)
  );

  gisb_datapath #(.LINES(LINES), .SENSE_EN(SENSE_EN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .readSel (readSel),
    .wrData  (regWrData),
    .lineIn  (lineIn),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .enableQ (enableQ),
    .type0Q  (type0Q),
    .type1Q  (type1Q),
    .type2Q  (type2Q),
    .statusQ (statusQ),
    .prevQ   (prevQ)
  );

endmodule

// File: rtl/gisb_checker.sv
module gisb_checker
  import gisb_pkg::*;
#(
  parameter int LINES    = 32,
  parameter int ADDR_W   = 5,
  parameter bit SENSE_EN = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [LINES-1:0]  lineIn,
  input logic              irqOut,
  input logic [LINES-1:0]  enableQ,
  input logic [LINES-1:0]  type0Q,
  input logic [LINES-1:0]  type1Q,
  input logic [LINES-1:0]  type2Q,
  input logic [LINES-1:0]  statusQ,
  input logic [LINES-1:0]  prevQ
);

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (enableQ == '0 && type2Q == '0 && &type0Q && &type1Q && statusQ == '0));

  assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((statusQ & ~$past(statusQ) & $past(~type1Q & ~type2Q & type0Q)
                      & ~$past(lineIn & ~prevQ)) == '0));

  assert_fall_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((statusQ & ~$past(statusQ) & $past(~type1Q & ~type2Q & ~type0Q)
                      & ~$past(~lineIn & prevQ)) == '0));

  generate
    if (SENSE_EN) begin : g_lvl
      assert_level_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (($past(type1Q & ~(lineIn ^ type0Q)) & ~statusQ) == '0));
    end else begin : g_off
      assert_quiet_bank_R11: assert property (@(posedge clk) disable iff (!rstN)
        (statusQ == '0) && !irqOut);
    end
  endgenerate

  assert_clear_needs_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && |(~statusQ & $past(statusQ)))
      |-> ($past(regWrEn) && $past(regAddr) == ADDR_W'(OFS_STATUS)));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !irqOut);

endmodule

bind gpio_irq_sense_bank gisb_checker #(
  .LINES(LINES), .ADDR_W(ADDR_W), .SENSE_EN(SENSE_EN)
) u_checker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .lineIn(lineIn), .irqOut(irqOut), .enableQ(enableQ), .type0Q(type0Q),
  .type1Q(type1Q), .type2Q(type2Q), .statusQ(statusQ), .prevQ(prevQ)
);

// File: tb/test_gpio_irq_sense_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_sense_bank;

  localparam int LINES  = 32;
  localparam int ADDR_W = 5;
  localparam logic [4:0] A_EN = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08,
                         A_T2 = 5'h0C, A_ST = 5'h10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [LINES-1:0]  regWrData = '0;
  logic [LINES-1:0]  lineIn = '0;
  logic [LINES-1:0]  rdA, rdB;
  logic              irqA, irqB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_sense_bank #(.LINES(LINES), .ADDR_W(ADDR_W), .SENSE_EN(1'b1)) i_gpio_irq_sense_bank (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdA), .lineIn(lineIn), .irqOut(irqA));

  gpio_irq_sense_bank #(.LINES(LINES), .ADDR_W(ADDR_W), .SENSE_EN(1'b0)) i_gpio_irq_sense_bank_quiet (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdB), .lineIn(lineIn), .irqOut(irqB));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] dA, output logic [31:0] dB);
    regAddr = a;
    #0.5;
    dA = rdA; dB = rdB;
  endtask

  task automatic setLine(input logic [31:0] v);
    @(negedge clk);
    lineIn = v;
    @(negedge clk);
  endtask

  task automatic mode(input logic [31:0] t0, input logic [31:0] t1, input logic [31:0] t2);
    wr(A_T1, t1); wr(A_T0, t0); wr(A_T2, t2);
    wr(A_ST, 32'hFFFF_FFFF);
  endtask

  task automatic expStatus(input string tag, input logic [31:0] e);
    logic [31:0] a, b;
    rd(A_ST, a, b);
    check(tag, a, e);
  endtask

  task automatic t_reset;
    logic [31:0] a, b;
    rd(A_EN, a, b); check("R1 enable", a, 32'h0);
    rd(A_T0, a, b); check("R1 type0", a, 32'hFFFF_FFFF);
    rd(A_T1, a, b); check("R1 type1", a, 32'hFFFF_FFFF);
    rd(A_T2, a, b); check("R1 type2", a, 32'h0);
    rd(A_ST, a, b); check("R1 status", a, 32'h0);
    check("R1 irq", {31'b0, irqA}, 32'h0);
  endtask

  task automatic t_rise;
    mode(32'hFFFF_FFFF, 32'h0, 32'h0);
    setLine(32'h0000_00F0);
    expStatus("R2 rising sets", 32'h0000_00F0);
    wr(A_ST, 32'hFFFF_FFFF);
    setLine(32'h0);
    expStatus("R2 falling ignored", 32'h0);
  endtask

  task automatic t_fall;
    mode(32'h0, 32'h0, 32'h0);
    setLine(32'h0000_FF00);
    expStatus("R3 rising ignored", 32'h0);
    setLine(32'h0000_0F00);
    expStatus("R3 falling sets", 32'h0000_F000);
    setLine(32'h0);
  endtask

  task automatic t_both;
    mode(32'h0000_0002, 32'h0, 32'hFFFF_FFFF);
    setLine(32'h0000_0003);
    expStatus("R4 both rise", 32'h0000_0003);
    wr(A_ST, 32'hFFFF_FFFF);
    setLine(32'h0);
    expStatus("R4 both fall", 32'h0000_0003);
  endtask

  task automatic t_w1c;
    mode(32'hFFFF_FFFF, 32'h0, 32'h0);
    setLine(32'h0000_00F0);
    wr(A_ST, 32'h0000_0030);
    expStatus("R7 clear ones", 32'h0000_00C0);
    wr(A_ST, 32'h0);
    expStatus("R7 zero no effect", 32'h0000_00C0);
    setLine(32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] st;
    st = 32'h0000_00C0;
    expStatus("R8 set while disabled", st);
    check("R8 irq disabled", {31'b0, irqA}, 32'h0);
    wr(A_EN, 32'h0000_0040);
    check("R8 irq enabled", {31'b0, irqA}, 32'h1);
    wr(A_EN, 32'h0000_0001);
    check("R8 irq other bit", {31'b0, irqA}, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_lvlHigh;
    mode(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    setLine(32'h0000_0003);
    wr(A_ST, 32'hFFFF_FFFF);
    expStatus("R5 level re-sets", 32'h0000_0003);
    setLine(32'h0);
    wr(A_ST, 32'hFFFF_FFFF);
    expStatus("R5 cleared after release", 32'h0);
  endtask

  task automatic t_lvlLow;
    setLine(32'hFFFF_FFFF);
    mode(32'h0, 32'hFFFF_FFFF, 32'h0);
    expStatus("R6 high no event", 32'h0);
    setLine(32'hFFFF_FFFE);
    expStatus("R6 low sets", 32'h0000_0001);
    wr(A_ST, 32'hFFFF_FFFF);
    expStatus("R6 low persists", 32'h0000_0001);
  endtask

  task automatic t_readback;
    logic [31:0] a, b;
    wr(A_T2, 32'h1234_5678);
    rd(A_T2, a, b); check("R10 type2 readback", a, 32'h1234_5678);
    wr(A_EN, 32'hA5A5_0000);
    rd(A_EN, a, b); check("R10 enable readback", a, 32'hA5A5_0000);
    rd(5'h14, a, b); check("R10 unmapped", a, 32'h0);
    rd(5'h1C, a, b); check("R10 unmapped high", a, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_quiet;
    logic [31:0] a, b;
    wr(A_EN, 32'hFFFF_FFFF);
    mode(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    setLine(32'h00FF_00FF);
    rd(A_ST, a, b);
    check("R11 quiet status", b, 32'h0);
    check("R11 quiet irq", {31'b0, irqB}, 32'h0);
    check("R11 live irq", {31'b0, irqA}, 32'h1);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_noSpurious;
    @(negedge clk);
    rstN = 1'b0;
    lineIn = 32'hA5A5_A5A5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mode(32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    expStatus("R9 steady no edge", 32'h0);
    setLine(32'hA5A5_A5A4);
    expStatus("R9 real edge seen", 32'h0000_0001);
  endtask

  initial begin
    lineIn = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_w1c();
    t_irq();
    t_lvlHigh();
    t_lvlLow();
    t_readback();
    t_quiet();
    t_noSpurious();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule